// File: doc/BRIEF.md
# Interrupt Request and Priority Controller

This controller gathers eight interrupt sources for a small CPU core and reports the winning one as a 3-bit vector index. The sources are two asynchronous counter pins with a selectable active edge, two timers, a serial transmitter, a serial receiver, an analog-converter completion strobe and a software break. Every source except the software break has its own request latch and enable bit. The software break has a latch only.

The counter pins pass through a synchronizer and an edge detector that always run, whether or not the pins are used as plain ports. An active edge therefore always sets its request latch, and only the enable bit decides whether the request is taken.

A timer overflow does not raise a request by itself. It arms the timer, and the request is latched on the next rising edge of that timer's count source. A global disable flag masks every source except the software break. Out of reset this flag is set.

The core reads and writes the latches and control fields through a byte-wide bus. It clears a serviced request by acknowledging its index.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the register reads are as follows: address 0 (request flags) reads 0x00, address 1 (enables) reads 0x00, address 2 (edge polarity) reads 0x00, address 3 (control) reads 0x01, and `irq_valid_o` is 0.
- R2: Polarity bit i at address 2 selects the active edge of counter pin i: 0 selects falling, 1 selects rising. An active edge sets request bit i three clock edges after the pin changes. The opposite edge sets nothing.
- R3: A counter-pin edge sets its request bit even while that source is disabled, but no interrupt is then presented.
- R4: A timer overflow strobe (timer 1 sets bit 2, timer 2 sets bit 3) sets no request on its own. The request bit is set at the clock edge where the first rise of that timer's count-source level after the overflow is seen. Later rises without a new overflow set nothing.
- R5: The serial transmit, serial receive, converter-done and software-break strobes set request bits 4, 5, 6 and 7 at the next clock edge.
- R6: Bit 0 at address 3 is the global disable flag. While it is 1, only the software break (index 7) can be presented. The break has no enable bit: address 1 bit 7 always reads 0, and a pending break is always presented.
- R7: `irq_valid_o` is 1 when any eligible request exists. A request is eligible when its bit is set, it is enabled, and the global flag is clear; the break is always eligible. `irq_idx_o` is the lowest eligible index, so index 0 has the highest priority. `irq_idx_o` is 0 when nothing is eligible.
- R8: Pulsing `ack_i` with `ack_idx_i` clears that request bit at the same clock edge.
- R9: A write to address 0 clears each request bit written as 0 and leaves each bit written as 1 unchanged.
- R10: When a set event and a clear (an acknowledge or a software write) reach the same request bit in the same cycle, the bit ends up set.
- R11: Address 1 holds enables in bits 6..0 and address 2 holds the polarity in bits 1..0. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_pin_i | input | 2 | Asynchronous counter pins |
| tmr_ovf_i | input | 2 | Timer overflow strobes |
| tmr_src_i | input | 2 | Timer count-source levels |
| ser_tx_evt_i | input | 1 | Serial transmit event strobe |
| ser_rx_evt_i | input | 1 | Serial receive event strobe |
| adc_done_i | input | 1 | Converter done strobe |
| brk_evt_i | input | 1 | Software break strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| ack_i | input | 1 | Acknowledge of a serviced request |
| ack_idx_i | input | 3 | Index being acknowledged |
| irq_valid_o | output | 1 | An eligible request is pending |
| irq_idx_o | output | 3 | Winning source index |

## Verification
Each result has a fixed latency, and the bench checks each one at that point:

- **Strobes, writes and acknowledges** show up in the flags and in the interrupt outputs after one clock edge.
- **Timer requests** appear at the edge that samples the count-source rise.
- **Pin edges** need three edges: two synchronizer stages, then the latch.

The bench drives inputs at the falling clock edge and samples results at a later falling edge. It probes a pin request at two edges, where the bit must still be clear, and again at three edges, where it must be set.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 8;
    localparam int IDX_W = $clog2(NSRC);
    localparam int DW    = 8;
    localparam int AW    = 2;
    localparam int NPIN  = 2;
    localparam int NTMR  = 2;

    typedef enum logic [IDX_W-1:0] {
        SRC_PIN0 = 3'd0,
        SRC_PIN1 = 3'd1,
        SRC_TMR1 = 3'd2,
        SRC_TMR2 = 3'd3,
        SRC_STX  = 3'd4,
        SRC_SRX  = 3'd5,
        SRC_ADC  = 3'd6,
        SRC_BRK  = 3'd7
    } src_e;

    typedef enum logic [AW-1:0] {
        REG_REQ = 2'd0,
        REG_EN  = 2'd1,
        REG_POL = 2'd2,
        REG_CTL = 2'd3
    } reg_e;

    typedef struct packed {
        logic [NSRC-1:0] req;
        logic [NSRC-2:0] en;
        logic [NPIN-1:0] pol;
        logic            gdis;
    } ctl_state_t;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic hit
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } pin_state_t;

    pin_state_t st_d, st_q;
    logic       lvl;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        lvl       = st_q.sync[SYNC_STAGES-1];
        hit       = pol ? (lvl & ~st_q.prev) : (~lvl & st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_tmr_gate.sv
module irq_tmr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic src,
    output logic hit
);
    typedef struct packed {
        logic armed;
        logic src_prev;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d          = st_q;
        rise          = src & ~st_q.src_prev;
        hit           = st_q.armed & rise;
        st_d.src_prev = src;
        st_d.armed    = ovf | (st_q.armed & ~rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     elig,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  cnt_pin_i,
    input  logic [NTMR-1:0]  tmr_ovf_i,
    input  logic [NTMR-1:0]  tmr_src_i,
    input  logic             ser_tx_evt_i,
    input  logic             ser_rx_evt_i,
    input  logic             adc_done_i,
    input  logic             brk_evt_i,
    input  logic [AW-1:0]    bus_addr_i,
    input  logic             bus_wr_i,
    input  logic [DW-1:0]    bus_wdata_i,
    output logic [DW-1:0]    bus_rdata_o,
    input  logic             ack_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    output logic             irq_valid_o,
    output logic [IDX_W-1:0] irq_idx_o
);
    ctl_state_t      st_d, st_q;
    logic [NPIN-1:0] pin_hit;
    logic [NTMR-1:0] tmr_hit;
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic [NSRC-1:0] elig;

    logic [NSRC-1:0] req_q;
    logic [NSRC-2:0] en_q;
    logic            gdis_q;
    assign req_q  = st_q.req;
    assign en_q   = st_q.en;
    assign gdis_q = st_q.gdis;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (cnt_pin_i[p]),
            .pol  (st_q.pol[p]),
            .hit  (pin_hit[p])
        );
    end

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        irq_tmr_gate u_gate (
            .clk  (clk),
            .rst_n(rst_n),
            .ovf  (tmr_ovf_i[t]),
            .src  (tmr_src_i[t]),
            .hit  (tmr_hit[t])
        );
    end

    always_comb begin
        st_d  = st_q;
        set_v = {brk_evt_i, adc_done_i, ser_rx_evt_i, ser_tx_evt_i, tmr_hit, pin_hit};
        clr_v = '0;
        if (ack_i) clr_v[ack_idx_i] = 1'b1;
        if (bus_wr_i) begin
            case (bus_addr_i)
                REG_REQ: clr_v = clr_v | ~bus_wdata_i;
                REG_EN:  st_d.en   = bus_wdata_i[NSRC-2:0];
                REG_POL: st_d.pol  = bus_wdata_i[NPIN-1:0];
                default: st_d.gdis = bus_wdata_i[0];
            endcase
        end
        st_d.req = (st_q.req & ~clr_v) | set_v;
        elig     = st_q.req & {1'b1, st_q.en & {(NSRC-1){~st_q.gdis}}};
        case (bus_addr_i)
            REG_REQ: bus_rdata_o = st_q.req;
            REG_EN:  bus_rdata_o = DW'(st_q.en);
            REG_POL: bus_rdata_o = DW'(st_q.pol);
            default: bus_rdata_o = DW'(st_q.gdis);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.gdis <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    irq_prio #(.N(NSRC), .IDX_W(IDX_W)) u_prio (
        .elig (elig),
        .valid(irq_valid_o),
        .idx  (irq_idx_o)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  req,
    input logic [NSRC-2:0]  en,
    input logic             gdis,
    input logic             adc_done,
    input logic             ack,
    input logic [IDX_W-1:0] ack_idx,
    input logic             irq_valid,
    input logic [IDX_W-1:0] irq_idx
);
    assert_adc_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_done |=> req[SRC_ADC]);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_idx == SRC_ADC && !adc_done) |=> !req[SRC_ADC]);

    assert_winner_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> req[irq_idx]);

    assert_top_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && req[0] && en[0] && !gdis) |-> irq_idx == SRC_PIN0);

    assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && gdis) |-> irq_idx == SRC_BRK);

    assert_brk_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req[SRC_BRK] |-> irq_valid);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_q),
    .en       (en_q),
    .gdis     (gdis_q),
    .adc_done (adc_done_i),
    .ack      (ack_i),
    .ack_idx  (ack_idx_i),
    .irq_valid(irq_valid_o),
    .irq_idx  (irq_idx_o)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cnt_pin = '0, tmr_ovf = '0, tmr_src = '0;
    logic       stx = 1'b0, srx = 1'b0, adc = 1'b0, brk = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       ack = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       irq_valid;
    logic [2:0] irq_idx;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_pin_i(cnt_pin), .tmr_ovf_i(tmr_ovf),
        .tmr_src_i(tmr_src), .ser_tx_evt_i(stx), .ser_rx_evt_i(srx),
        .adc_done_i(adc), .brk_evt_i(brk), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ack_i(ack), .ack_idx_i(ack_idx),
        .irq_valid_o(irq_valid), .irq_idx_o(irq_idx)
    );

    // row: {en[6:0], gdis, strobes {brk,adc,rx,tx}, exp_valid, exp_idx[2:0], exp_req[7:0]}
    localparam logic [23:0] VEC [10] = '{
        {7'h7F, 1'b0, 4'b0001, 1'b1, 3'd4, 8'h10},
        {7'h7F, 1'b0, 4'b0111, 1'b1, 3'd4, 8'h70},
        {7'h7F, 1'b0, 4'b1110, 1'b1, 3'd5, 8'hE0},
        {7'h7F, 1'b1, 4'b0111, 1'b0, 3'd0, 8'h70},
        {7'h7F, 1'b1, 4'b1111, 1'b1, 3'd7, 8'hF0},
        {7'h00, 1'b0, 4'b1000, 1'b1, 3'd7, 8'h80},
        {7'h00, 1'b0, 4'b0111, 1'b0, 3'd0, 8'h70},
        {7'h40, 1'b0, 4'b0011, 1'b0, 3'd0, 8'h30},
        {7'h40, 1'b0, 4'b0111, 1'b1, 3'd6, 8'h70},
        {7'h20, 1'b0, 4'b1110, 1'b1, 3'd5, 8'hE0}
    };

    task automatic cyc(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        cyc(3);
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        rreg(2'd0, v); chk("R1 req", v, 8'h00);
        rreg(2'd1, v); chk("R1 en", v, 8'h00);
        rreg(2'd2, v); chk("R1 pol", v, 8'h00);
        rreg(2'd3, v); chk("R1 ctl", v, 8'h01);
        chk("R1 valid", {7'b0, irq_valid}, 8'h00);

        // R11 field widths
        wreg(2'd1, 8'hFF); rreg(2'd1, v); chk("R11 en", v, 8'h7F);
        wreg(2'd2, 8'hFF); rreg(2'd2, v); chk("R11 pol", v, 8'h03);
        wreg(2'd3, 8'hFF); rreg(2'd3, v); chk("R11 ctl", v, 8'h01);
        wreg(2'd2, 8'h00);

        // table walk: R5, R6, R7
        for (int r = 0; r < 10; r++) begin
            logic [23:0] e;
            e = VEC[r];
            wreg(2'd3, {7'b0, e[16]});
            wreg(2'd1, {1'b0, e[23:17]});
            wreg(2'd0, 8'h00);
            {brk, adc, srx, stx} = e[15:12];
            cyc();
            {brk, adc, srx, stx} = 4'b0;
            rreg(2'd0, v); chk("R5 req flags", v, e[7:0]);
            chk("R7 valid", {7'b0, irq_valid}, {7'b0, e[11]});
            chk("R7 index", {5'b0, irq_idx}, {5'b0, e[10:8]});
        end

        // R2 / R3 counter pins
        wreg(2'd0, 8'h00); wreg(2'd3, 8'h01); wreg(2'd1, 8'h00); wreg(2'd2, 8'h00);
        cnt_pin[0] = 1'b1; cyc(4);
        rreg(2'd0, v); chk("R2 opposite edge", v, 8'h00);
        cnt_pin[0] = 1'b0; cyc(2);
        rreg(2'd0, v); chk("R2 latency two edges", v, 8'h00);
        cyc();
        rreg(2'd0, v); chk("R3 latched while disabled", v, 8'h01);
        chk("R3 not presented", {7'b0, irq_valid}, 8'h00);
        wreg(2'd2, 8'h02);
        cnt_pin[1] = 1'b1; cyc(3);
        rreg(2'd0, v); chk("R2 rising pin1", v, 8'h03);
        wreg(2'd3, 8'h00); wreg(2'd1, 8'h7F);
        chk("R7 pin0 wins", {4'b0, irq_valid, irq_idx}, 8'h08);
        ack = 1'b1; ack_idx = 3'd0; cyc(); ack = 1'b0;
        rreg(2'd0, v); chk("R8 ack pin0", v, 8'h02);
        chk("R7 next winner", {4'b0, irq_valid, irq_idx}, 8'h09);

        // R4 timers
        wreg(2'd0, 8'h00);
        tmr_ovf[0] = 1'b1; cyc(); tmr_ovf[0] = 1'b0; cyc();
        rreg(2'd0, v); chk("R4 overflow alone", v, 8'h00);
        tmr_src[0] = 1'b1; cyc();
        rreg(2'd0, v); chk("R4 set on source rise", v, 8'h04);
        wreg(2'd0, 8'h00);
        tmr_src[0] = 1'b0; cyc(); tmr_src[0] = 1'b1; cyc();
        rreg(2'd0, v); chk("R4 one per overflow", v, 8'h00);
        tmr_ovf[1] = 1'b1; cyc(); tmr_ovf[1] = 1'b0;
        tmr_src[1] = 1'b1; cyc();
        rreg(2'd0, v); chk("R4 timer2", v, 8'h08);

        // R9 software clear
        wreg(2'd0, 8'h00);
        {adc, srx, stx} = 3'b111; cyc(); {adc, srx, stx} = 3'b000;
        wreg(2'd0, 8'hFE); rreg(2'd0, v); chk("R9 ones keep", v, 8'h70);
        wreg(2'd0, 8'hBF); rreg(2'd0, v); chk("R9 zero clears", v, 8'h30);

        // R10 set beats clear
        wreg(2'd0, 8'h00);
        adc = 1'b1; ack = 1'b1; ack_idx = 3'd6; cyc(); adc = 1'b0; ack = 1'b0;
        rreg(2'd0, v); chk("R10 set vs ack", v, 8'h40);
        adc = 1'b1; wreg(2'd0, 8'h00); adc = 1'b0;
        rreg(2'd0, v); chk("R10 set vs write", v, 8'h40);
        ack = 1'b1; ack_idx = 3'd6; cyc(); ack = 1'b0;
        rreg(2'd0, v); chk("R8 ack adc", v, 8'h00);

        // R6 break ignores global disable
        wreg(2'd3, 8'h01);
        brk = 1'b1; cyc(); brk = 1'b0;
        chk("R6 break presented", {4'b0, irq_valid, irq_idx}, 8'h0F);
        wreg(2'd0, 8'h00);
        chk("R6 cleared", {7'b0, irq_valid}, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule